// File: doc/BRIEF.md
# Interrupt and Bus Request Arbiter

This block sits beside the control sequencer of an 8-bit processor core. It decides when three external requests are serviced: a request from another master to take over the bus, a non-maskable interrupt and a maskable interrupt. It also tells the sequencer what to do at each boundary. The three request pins are active low and asynchronous. Each one passes through a synchronizer before the block uses it. The sequencer gives the block two strobes. One marks the last cycle of each machine cycle and the other marks the last cycle of each instruction. The block also reads the current state of the first interrupt-enable flip-flop, the selected interrupt mode and a flag that is set while the processor is halted.

A bus request can be granted at any machine-cycle boundary. When it is granted, the block first raises a float enable for the address, data and control lines, and only then drives the acknowledge low. When the request goes away, the acknowledge is withdrawn first and the float enable is released one cycle later. Interrupts are considered only at instruction boundaries, and only while the processor owns the bus. A non-maskable interrupt is latched on a falling edge and is always taken, whatever the enable flip-flop holds. A maskable interrupt is taken only when the enable flip-flop is set. At an accepted interrupt the block issues a one-cycle service pulse, writes new values for the enable flip-flops and, if the processor was halted, a halt-release pulse.

Top module: `irq_bus_arbiter`

## Requirements
- R1: The block samples an active bus request only in a cycle where the machine-cycle-end strobe is high. The float enable rises at the next clock edge. No interrupt service pulse is issued at that boundary, nor while the float enable is high.
- R2: The bus acknowledge goes low exactly one cycle after the float enable rises. When the request is withdrawn, the acknowledge returns high while the float enable stays high, and the float enable falls one cycle later.
- R3: A falling edge on the non-maskable pin sets a pending latch. Keeping the pin low does not produce a second service; a second service needs a new falling edge.
- R4: A pending non-maskable interrupt is serviced at an instruction-end strobe whatever the state of the enable flip-flop. The service pulse appears in the cycle after the strobe, and the vector output reads 0x0066.
- R5: When both interrupts are pending at the same boundary, only the non-maskable one is serviced. The maskable one is serviced at a later boundary.
- R6: A maskable interrupt is serviced only at an instruction-end strobe, and only when its pin is low and the first enable flip-flop is 1. A machine-cycle-end strobe alone never services it.
- R7: The maskable service pulse reports the interrupt mode sampled at the boundary. Mode codes 0, 1 and 2 are passed through unchanged, and code 3 is reported as 0.
- R8: When either service is issued while the halted flag was high at the boundary, the halt-release output pulses in the same cycle as the service pulse. At no other time does it pulse.
- R9: With a non-maskable service, the enable write strobe pulses with first enable = 0 and second enable = the sampled first enable. With a maskable service, the write strobe pulses with both enables = 0.
- R10: Servicing clears the non-maskable pending latch. If a new falling edge is detected in the same cycle as the service, the latch stays set and a second service follows at the next instruction-end strobe.
- R11: Each pin passes through two synchronizing flip-flops. An interrupt pin that falls one cycle before an instruction-end strobe is not yet seen at that strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| busrq_n_i | input | 1 | Bus request from another master, active low, asynchronous |
| nmi_n_i | input | 1 | Non-maskable interrupt pin, active low, asynchronous |
| int_n_i | input | 1 | Maskable interrupt pin, active low, asynchronous |
| mcyc_end_i | input | 1 | High in the last cycle of a machine cycle |
| instr_end_i | input | 1 | High in the last cycle of an instruction |
| iff1_i | input | 1 | Current state of the first interrupt-enable flip-flop |
| int_mode_i | input | 2 | Selected maskable interrupt mode (0, 1, 2) |
| halted_i | input | 1 | Processor is in the halt state |
| busack_n_o | output | 1 | Bus acknowledge, active low |
| float_o | output | 1 | Float enable for the address, data and control lines |
| nmi_take_o | output | 1 | One-cycle non-maskable service request |
| nmi_vector_o | output | 16 | Restart address for non-maskable service |
| int_take_o | output | 1 | One-cycle maskable service request |
| int_mode_o | output | 2 | Mode to use for the maskable service |
| iff_wr_o | output | 1 | Write strobe for the enable flip-flops |
| iff1_o | output | 1 | New value of the first enable flip-flop |
| iff2_o | output | 1 | New value of the second enable flip-flop |
| halt_rel_o | output | 1 | One-cycle pulse to leave the halt state |

## Verification
The assertions assume the sequencer behaves sensibly: it raises the instruction-end strobe only in cycles where it also owns the bus, and it holds the enable and mode inputs steady in the strobe cycle. They also assume the request pins change only between clock edges and that each level is held for longer than the synchronizer delay. The bench drives every input at the falling clock edge, waits out the two synchronizer stages before it pulses any strobe, and pulses each strobe for exactly one cycle. This means every boundary decision falls on a known clock edge.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;

    // ownership of the external bus
    typedef enum logic [1:0] {
        BUS_OWN    = 2'd0,
        BUS_FLOAT  = 2'd1,
        BUS_GRANT  = 2'd2,
        BUS_RETURN = 2'd3
    } bus_st_e;

    // maskable interrupt modes
    typedef enum logic [1:0] {
        IMODE_0 = 2'd0,
        IMODE_1 = 2'd1,
        IMODE_2 = 2'd2
    } imode_e;

    // decision made at an instruction boundary
    typedef struct packed {
        logic   nmi;
        logic   irq;
        imode_e mode;
        logic   wake;
        logic   en1;
    } svc_t;

    localparam int unsigned PIN_COUNT = 3;
    localparam int unsigned PIN_BREQ  = 0;
    localparam int unsigned PIN_NMI   = 1;
    localparam int unsigned PIN_IRQ   = 2;

    // code 3 is not a valid mode and falls back to mode 0
    function automatic imode_e norm_mode(input logic [1:0] code);
        case (code)
            2'd1:    return IMODE_1;
            2'd2:    return IMODE_2;
            default: return IMODE_0;
        endcase
    endfunction

endpackage

// File: rtl/arb_pin_sync.sv
module arb_pin_sync #(
    parameter int unsigned WIDTH  = 3,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] pin_i,
    output logic [WIDTH-1:0] pin_o
);
    localparam int unsigned LAST = STAGES - 1;

    logic [STAGES-1:0][WIDTH-1:0] chain_q;

    // the pins are active low, so the idle value after reset is all ones
    always_ff @(posedge clk) begin
        if (rst) begin
            chain_q <= '1;
        end else begin
            chain_q[0] <= pin_i;
            for (int s = 1; s < STAGES; s++) begin
                chain_q[s] <= chain_q[s-1];
            end
        end
    end

    assign pin_o = chain_q[LAST];
endmodule

// File: rtl/arb_nmi_latch.sv
module arb_nmi_latch (
    input  logic clk,
    input  logic rst,
    input  logic nmi_n_s,
    input  logic clear_i,
    output logic pend_o
);
    logic prev_q;
    logic pend_q;
    logic fall;

    assign fall = prev_q & ~nmi_n_s;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= 1'b1;
            pend_q <= 1'b0;
        end else begin
            prev_q <= nmi_n_s;
            // a fresh edge wins over the clear so it is not lost
            if (fall)         pend_q <= 1'b1;
            else if (clear_i) pend_q <= 1'b0;
        end
    end

    assign pend_o = pend_q;
endmodule

// File: rtl/arb_bus_ctl.sv
module arb_bus_ctl
    import irq_arb_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic breq_act_i,
    input  logic mcyc_end_i,
    output logic owned_o,
    output logic accept_o,
    output logic float_o,
    output logic ack_n_o
);
    bus_st_e st_q, st_d;

    assign owned_o  = (st_q == BUS_OWN);
    assign accept_o = owned_o & mcyc_end_i & breq_act_i;

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            BUS_OWN:    if (accept_o)    st_d = BUS_FLOAT;
            BUS_FLOAT:  st_d = breq_act_i ? BUS_GRANT : BUS_RETURN;
            BUS_GRANT:  if (!breq_act_i) st_d = BUS_RETURN;
            BUS_RETURN: st_d = BUS_OWN;
            default:    st_d = BUS_OWN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= BUS_OWN;
        else     st_q <= st_d;
    end

    assign float_o = (st_q != BUS_OWN);
    assign ack_n_o = (st_q != BUS_GRANT);
endmodule

// File: rtl/arb_service_sel.sv
module arb_service_sel
    import irq_arb_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       boundary_i,
    input  logic       nmi_pend_i,
    input  logic       irq_act_i,
    input  logic       iff1_i,
    input  logic [1:0] mode_i,
    input  logic       halted_i,
    output logic       nmi_go_o,
    output svc_t       svc_o
);
    svc_t dec, svc_q;

    always_comb begin
        dec      = '0;
        dec.nmi  = boundary_i & nmi_pend_i;
        dec.irq  = boundary_i & ~nmi_pend_i & iff1_i & irq_act_i;
        dec.mode = norm_mode(mode_i);
        dec.wake = (dec.nmi | dec.irq) & halted_i;
        dec.en1  = iff1_i;
    end

    assign nmi_go_o = dec.nmi;

    always_ff @(posedge clk) begin
        if (rst) svc_q <= '0;
        else     svc_q <= dec;
    end

    assign svc_o = svc_q;
endmodule

// File: rtl/irq_bus_arbiter.sv
module irq_bus_arbiter
    import irq_arb_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2,
    parameter logic [15:0] NMI_VECTOR  = 16'h0066
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        busrq_n_i,
    input  logic        nmi_n_i,
    input  logic        int_n_i,
    input  logic        mcyc_end_i,
    input  logic        instr_end_i,
    input  logic        iff1_i,
    input  logic [1:0]  int_mode_i,
    input  logic        halted_i,
    output logic        busack_n_o,
    output logic        float_o,
    output logic        nmi_take_o,
    output logic [15:0] nmi_vector_o,
    output logic        int_take_o,
    output logic [1:0]  int_mode_o,
    output logic        iff_wr_o,
    output logic        iff1_o,
    output logic        iff2_o,
    output logic        halt_rel_o
);
    logic [PIN_COUNT-1:0] pins_raw, pins_s;
    logic nmi_pend, nmi_go;
    logic owned, accept;
    logic boundary;
    svc_t svc;

    assign pins_raw[PIN_BREQ] = busrq_n_i;
    assign pins_raw[PIN_NMI]  = nmi_n_i;
    assign pins_raw[PIN_IRQ]  = int_n_i;

    arb_pin_sync #(.WIDTH(PIN_COUNT), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst   (rst),
        .pin_i (pins_raw),
        .pin_o (pins_s)
    );

    arb_nmi_latch u_nmi (
        .clk     (clk),
        .rst     (rst),
        .nmi_n_s (pins_s[PIN_NMI]),
        .clear_i (nmi_go),
        .pend_o  (nmi_pend)
    );

    arb_bus_ctl u_bus (
        .clk        (clk),
        .rst        (rst),
        .breq_act_i (~pins_s[PIN_BREQ]),
        .mcyc_end_i (mcyc_end_i),
        .owned_o    (owned),
        .accept_o   (accept),
        .float_o    (float_o),
        .ack_n_o    (busack_n_o)
    );

    // interrupts only at an instruction end, with the bus owned and not being handed over
    assign boundary = instr_end_i & owned & ~accept;

    arb_service_sel u_sel (
        .clk        (clk),
        .rst        (rst),
        .boundary_i (boundary),
        .nmi_pend_i (nmi_pend),
        .irq_act_i  (~pins_s[PIN_IRQ]),
        .iff1_i     (iff1_i),
        .mode_i     (int_mode_i),
        .halted_i   (halted_i),
        .nmi_go_o   (nmi_go),
        .svc_o      (svc)
    );

    assign nmi_take_o   = svc.nmi;
    assign nmi_vector_o = NMI_VECTOR;
    assign int_take_o   = svc.irq;
    assign int_mode_o   = svc.mode;
    assign iff_wr_o     = svc.nmi | svc.irq;
    assign iff1_o       = 1'b0;
    assign iff2_o       = svc.nmi & svc.en1;
    assign halt_rel_o   = svc.wake;
endmodule

// File: rtl/irq_bus_arbiter_chk.sv
module irq_bus_arbiter_chk (
    input logic       clk,
    input logic       rst,
    input logic       mcyc_end_i,
    input logic       instr_end_i,
    input logic       iff1_i,
    input logic [1:0] int_mode_i,
    input logic       halted_i,
    input logic       busack_n_o,
    input logic       float_o,
    input logic       nmi_take_o,
    input logic       int_take_o,
    input logic [1:0] int_mode_o,
    input logic       iff_wr_o,
    input logic       iff1_o,
    input logic       iff2_o,
    input logic       halt_rel_o
);
    // R1
    float_on_mcyc_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(float_o) |-> $past(mcyc_end_i));
    // R1
    no_svc_floated_chk: assert property (@(posedge clk) disable iff (rst)
        float_o |-> !(nmi_take_o || int_take_o));
    // R2
    ack_after_float_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(busack_n_o) |-> $past(float_o));
    // R2
    float_after_ack_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(busack_n_o) |=> !float_o);
    // R4
    nmi_at_instr_chk: assert property (@(posedge clk) disable iff (rst)
        nmi_take_o |-> $past(instr_end_i));
    // R5
    svc_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
        $countones({nmi_take_o, int_take_o}) <= 1);
    // R6
    int_needs_enable_chk: assert property (@(posedge clk) disable iff (rst)
        int_take_o |-> ($past(instr_end_i) && $past(iff1_i)));
    // R7
    int_mode_chk: assert property (@(posedge clk) disable iff (rst)
        int_take_o |-> (int_mode_o == (($past(int_mode_i) == 2'd3) ? 2'd0 : $past(int_mode_i))));
    // R8
    halt_rel_chk: assert property (@(posedge clk) disable iff (rst)
        halt_rel_o |-> ($past(halted_i) && (nmi_take_o || int_take_o)));
    // R9
    nmi_iff_chk: assert property (@(posedge clk) disable iff (rst)
        nmi_take_o |-> (iff_wr_o && !iff1_o && (iff2_o == $past(iff1_i))));
    // R9
    int_iff_chk: assert property (@(posedge clk) disable iff (rst)
        int_take_o |-> (iff_wr_o && !iff1_o && !iff2_o));
endmodule

bind irq_bus_arbiter irq_bus_arbiter_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .mcyc_end_i  (mcyc_end_i),
    .instr_end_i (instr_end_i),
    .iff1_i      (iff1_i),
    .int_mode_i  (int_mode_i),
    .halted_i    (halted_i),
    .busack_n_o  (busack_n_o),
    .float_o     (float_o),
    .nmi_take_o  (nmi_take_o),
    .int_take_o  (int_take_o),
    .int_mode_o  (int_mode_o),
    .iff_wr_o    (iff_wr_o),
    .iff1_o      (iff1_o),
    .iff2_o      (iff2_o),
    .halt_rel_o  (halt_rel_o)
);

// File: tb/test_irq_bus_arbiter.sv
module test_irq_bus_arbiter;
    logic        clk = 1'b0;
    logic        rst;
    logic        busrq_n, nmi_n, int_n, mcyc_end, instr_end, iff1, halted;
    logic [1:0]  mode;
    logic        busack_n, flt, nmi_take, int_take, iff_wr, iff1_n, iff2_n, halt_rel;
    logic [15:0] vec;
    logic [1:0]  mode_o;
    int          checks = 0;
    int          errors = 0;
    bit          done = 1'b0;

    always #2.5 clk = ~clk;

    irq_bus_arbiter i_irq_bus_arbiter (
        .clk(clk), .rst(rst), .busrq_n_i(busrq_n), .nmi_n_i(nmi_n), .int_n_i(int_n),
        .mcyc_end_i(mcyc_end), .instr_end_i(instr_end), .iff1_i(iff1),
        .int_mode_i(mode), .halted_i(halted), .busack_n_o(busack_n), .float_o(flt),
        .nmi_take_o(nmi_take), .nmi_vector_o(vec), .int_take_o(int_take),
        .int_mode_o(mode_o), .iff_wr_o(iff_wr), .iff1_o(iff1_n), .iff2_o(iff2_n),
        .halt_rel_o(halt_rel)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic cyc(input int n = 1);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    // one-cycle instruction-end strobe, leaves sampling one cycle after it
    task automatic instr_pulse();
        instr_end = 1'b1;
        cyc();
        instr_end = 1'b0;
    endtask

    task automatic t_reset();
        chk("R2 reset ack", busack_n, 1);
        chk("R1 reset float", flt, 0);
        chk("R4 reset nmi", nmi_take, 0);
        chk("R6 reset int", int_take, 0);
        chk("R8 reset halt", halt_rel, 0);
    endtask

    task automatic t_nmi_basic();
        iff1 = 1'b0;
        nmi_n = 1'b0;
        cyc(3);
        instr_pulse();
        chk("R4 nmi take with iff1=0", nmi_take, 1);
        chk("R4 vector", vec, 16'h0066);
        chk("R9 nmi iff_wr", iff_wr, 1);
        chk("R9 nmi iff1", iff1_n, 0);
        chk("R9 nmi iff2 copy", iff2_n, 0);
        cyc();
        chk("R4 nmi pulse one cycle", nmi_take, 0);
        cyc(3);
        instr_pulse();
        chk("R3 held low no retrigger", nmi_take, 0);
        chk("R10 latch cleared", iff_wr, 0);
        nmi_n = 1'b1;
        cyc(3);
    endtask

    task automatic t_nmi_copy();
        iff1 = 1'b1;
        nmi_n = 1'b0;
        cyc(3);
        instr_pulse();
        chk("R9 nmi iff2 copies 1", iff2_n, 1);
        chk("R9 nmi iff1 cleared", iff1_n, 0);
        nmi_n = 1'b1;
        cyc(3);
        iff1 = 1'b0;
    endtask

    task automatic t_nmi_overlap();
        nmi_n = 1'b0;
        cyc(3);
        nmi_n = 1'b1;
        cyc(3);
        // new fall: synced after two edges, edge seen in the next cycle
        nmi_n = 1'b0;
        cyc(2);
        instr_pulse();
        chk("R10 first service", nmi_take, 1);
        cyc();
        instr_pulse();
        chk("R10 held edge serviced", nmi_take, 1);
        nmi_n = 1'b1;
        cyc(3);
    endtask

    task automatic t_int();
        iff1 = 1'b0;
        int_n = 1'b0;
        cyc(3);
        instr_pulse();
        chk("R6 int masked", int_take, 0);
        iff1 = 1'b1;
        mcyc_end = 1'b1;
        cyc();
        mcyc_end = 1'b0;
        chk("R6 mcyc end alone", int_take, 0);
        mode = 2'd2;
        instr_pulse();
        chk("R6 int take", int_take, 1);
        chk("R7 mode 2", mode_o, 2);
        chk("R9 int iff_wr", iff_wr, 1);
        chk("R9 int iff2", iff2_n, 0);
        mode = 2'd1;
        instr_pulse();
        chk("R7 mode 1", mode_o, 1);
        mode = 2'd3;
        instr_pulse();
        chk("R7 mode 3 as 0", {int_take, mode_o}, {1'b1, 2'd0});
        int_n = 1'b1;
        cyc(3);
        instr_pulse();
        chk("R6 pin released", int_take, 0);
        iff1 = 1'b0;
        mode = 2'd0;
    endtask

    task automatic t_sync();
        iff1 = 1'b1;
        int_n = 1'b0;
        instr_pulse();
        chk("R11 not yet synced", int_take, 0);
        int_n = 1'b1;
        cyc(3);
        iff1 = 1'b0;
    endtask

    task automatic t_priority();
        iff1 = 1'b1;
        int_n = 1'b0;
        nmi_n = 1'b0;
        cyc(3);
        instr_pulse();
        chk("R5 nmi first", {nmi_take, int_take}, 2'b10);
        instr_pulse();
        chk("R5 int after", {nmi_take, int_take}, 2'b01);
        int_n = 1'b1;
        nmi_n = 1'b1;
        cyc(3);
        iff1 = 1'b0;
    endtask

    task automatic t_halt();
        halted = 1'b1;
        instr_pulse();
        chk("R8 no wake without service", halt_rel, 0);
        nmi_n = 1'b0;
        cyc(3);
        instr_pulse();
        chk("R8 wake on nmi", {nmi_take, halt_rel}, 2'b11);
        nmi_n = 1'b1;
        cyc(3);
        iff1 = 1'b1;
        int_n = 1'b0;
        cyc(3);
        instr_pulse();
        chk("R8 wake on int", {int_take, halt_rel}, 2'b11);
        halted = 1'b0;
        instr_pulse();
        chk("R8 not halted", {int_take, halt_rel}, 2'b10);
        int_n = 1'b1;
        iff1 = 1'b0;
        cyc(3);
    endtask

    task automatic t_bus();
        busrq_n = 1'b0;
        nmi_n = 1'b0;
        cyc(3);
        chk("R1 waits for mcyc end", flt, 0);
        mcyc_end = 1'b1;
        instr_end = 1'b1;
        cyc();
        mcyc_end = 1'b0;
        instr_end = 1'b0;
        chk("R1 float up", flt, 1);
        chk("R1 nmi deferred", nmi_take, 0);
        chk("R2 ack not yet", busack_n, 1);
        cyc();
        chk("R2 ack low", busack_n, 0);
        chk("R2 float held", flt, 1);
        instr_pulse();
        chk("R1 no service while granted", nmi_take, 0);
        busrq_n = 1'b1;
        cyc(2);
        chk("R2 still granted", busack_n, 0);
        cyc();
        chk("R2 ack released first", {busack_n, flt}, 2'b11);
        cyc();
        chk("R2 float released", flt, 0);
        instr_pulse();
        chk("R1 deferred nmi taken", nmi_take, 1);
        nmi_n = 1'b1;
        cyc(3);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        rst = 1'b1;
        busrq_n = 1'b1; nmi_n = 1'b1; int_n = 1'b1;
        mcyc_end = 1'b0; instr_end = 1'b0; iff1 = 1'b0; halted = 1'b0; mode = 2'd0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_nmi_basic();
        t_nmi_copy();
        t_nmi_overlap();
        t_int();
        t_sync();
        t_priority();
        t_halt();
        t_bus();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule